// File: doc/BRIEF.md
# Serial Receive Word Assembler with Comma Alignment

This block sits behind a clock-recovery front end and turns a recovered serial bit stream, one bit per bit-rate clock, into 10-bit parallel words. The earliest bit of each word ends up in bit 0. A new word normally appears every ten bit clocks. Two strobes, each firing on every other word, mark which of two interleaved half-rate output phases carries the word. A downstream consumer can clock alternate words on alternate strobes.

When alignment is switched on, the block watches a 10-bit sliding window of the most recent bits for the 7-bit comma prefix. On the first match it moves the word boundary at once, so the comma occupies bits 0 to 6 of the word it issues. It flags that word and places it on the phase-1 strobe. When the line-present input is low, the data outputs read all ones and comma detection is suppressed.

Top module: `rx_deser_align`

## Requirements
- R1: With no realignment, a word is issued every 10 bit clocks; bit i of the word is the i-th bit received (bit 0 first), and the word and strobes update on the clock edge that samples its 10th bit.
- R2: With `align_en` and `sig_ok` high, a comma that already sits on the word boundary is issued with `comma_flag` high and the boundary is unchanged.
- R3: With `align_en` and `sig_ok` high, a comma at any bit offset is issued as a word on the edge that samples its 10th bit (bits 0..6 equal 0,0,1,1,1,1,1 in arrival order, i.e. `word_out[6:0]` = 7'b1111100). The next word follows 10 bit clocks later.
- R4: With `align_en` low, no realignment happens and `comma_flag` stays low.
- R5: `phase0_en` and `phase1_en` are one-cycle pulses issued with each new word, never together, and they alternate from word to word.
- R6: A comma word is issued on `phase1_en`, and the word after it on `phase0_en`.
- R7: While `sig_ok` is low, `word_out` is all ones (10'h3FF).
- R8: While `sig_ok` is low, commas cause no realignment and `comma_flag` is low.
- R9: Synchronous active-high reset clears the word to zero, drops both strobes and the flag, and restarts the bit count so that the first word follows 10 bit clocks after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Recovered serial data bit |
| align_en | input | 1 | Enables comma search and realignment |
| sig_ok | input | 1 | Line signal present; low forces all-ones data |
| word_out | output | 10 | Assembled word, bit 0 received first |
| comma_flag | output | 1 | High with a word aligned on a comma |
| phase0_en | output | 1 | Pulse marking a word on output phase 0 |
| phase1_en | output | 1 | Pulse marking a word on output phase 1 |

## Verification
A wrong bit counter shows up within one word time as a strobe and a word change on the wrong clock edge. A wrong window or match shows up as a mis-shifted word or a missing or spurious flag on the edge that completes a comma. A phase register out of step shows up on the very next word after a comma, on the wrong strobe. The reference model predicts every output on every bit clock, so such faults are reported in the cycle they first appear at the ports.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

    localparam int WORD_W  = 10;
    localparam int COMMA_W = 7;
    localparam int CNT_W   = $clog2(WORD_W);

    // comma prefix, bit 0 is the earliest bit: 0,0,1,1,1,1,1
    localparam logic [COMMA_W-1:0] COMMA_PAT = 7'b1111100;

    typedef enum logic [1:0] {
        EV_NONE,
        EV_BOUNDARY,
        EV_ALIGN
    } rxd_event_e;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              comma;
        logic              ph0;
        logic              ph1;
    } rxd_word_t;

    function automatic logic is_comma(input logic [WORD_W-1:0] w);
        return w[COMMA_W-1:0] == COMMA_PAT;
    endfunction

endpackage

// File: rtl/rxd_window.sv
module rxd_window
    import rxd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_in,
    output logic [WORD_W-1:0] win_next,
    output logic              hit
);

    logic [WORD_W-1:0] win;

    // newest bit enters at the top, oldest sits at bit 0
    always_comb begin
        win_next = {ser_in, win[WORD_W-1:1]};
        hit      = is_comma(win_next);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win <= '0;
        end else begin
            win <= win_next;
        end
    end

endmodule

// File: rtl/rxd_framer.sv
module rxd_framer
    import rxd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hit,
    input  logic       align_en,
    input  logic       sig_ok,
    output rxd_event_e ev,
    output logic       ph_sel
);

    logic [CNT_W-1:0] cnt;
    logic             next_ph;

    always_comb begin
        if (hit && align_en && sig_ok) begin
            ev = EV_ALIGN;
        end else if (cnt == CNT_W'(WORD_W - 1)) begin
            ev = EV_BOUNDARY;
        end else begin
            ev = EV_NONE;
        end
        ph_sel = (ev == EV_ALIGN) ? 1'b1 : next_ph;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            next_ph <= 1'b0;
        end else begin
            unique case (ev)
                EV_ALIGN: begin
                    cnt     <= '0;
                    next_ph <= 1'b0;
                end
                EV_BOUNDARY: begin
                    cnt     <= '0;
                    next_ph <= ~next_ph;
                end
                default: begin
                    cnt     <= cnt + 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/rxd_outreg.sv
module rxd_outreg
    import rxd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  rxd_event_e        ev,
    input  logic              ph_sel,
    input  logic [WORD_W-1:0] win_next,
    input  logic              align_en,
    input  logic              sig_ok,
    output logic [WORD_W-1:0] word_out,
    output logic              comma_flag,
    output logic              phase0_en,
    output logic              phase1_en
);

    rxd_word_t r;

    always_ff @(posedge clk) begin
        if (rst) begin
            r <= '0;
        end else begin
            r.comma <= 1'b0;
            r.ph0   <= 1'b0;
            r.ph1   <= 1'b0;
            if (ev != EV_NONE) begin
                r.data  <= win_next;
                r.comma <= (ev == EV_ALIGN);
                r.ph1   <= ph_sel;
                r.ph0   <= ~ph_sel;
            end
        end
    end

    always_comb begin
        word_out   = sig_ok ? r.data : '1;
        comma_flag = r.comma & align_en & sig_ok;
        phase0_en  = r.ph0;
        phase1_en  = r.ph1;
    end

endmodule

// File: rtl/rx_deser_align.sv
module rx_deser_align
    import rxd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_in,
    input  logic              align_en,
    input  logic              sig_ok,
    output logic [WORD_W-1:0] word_out,
    output logic              comma_flag,
    output logic              phase0_en,
    output logic              phase1_en
);

    logic [WORD_W-1:0] win_next;
    logic              hit;
    rxd_event_e        ev;
    logic              ph_sel;

    rxd_window u_window (
        .clk      (clk),
        .rst      (rst),
        .ser_in   (ser_in),
        .win_next (win_next),
        .hit      (hit)
    );

    rxd_framer u_framer (
        .clk      (clk),
        .rst      (rst),
        .hit      (hit),
        .align_en (align_en),
        .sig_ok   (sig_ok),
        .ev       (ev),
        .ph_sel   (ph_sel)
    );

    rxd_outreg u_outreg (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .ph_sel     (ph_sel),
        .win_next   (win_next),
        .align_en   (align_en),
        .sig_ok     (sig_ok),
        .word_out   (word_out),
        .comma_flag (comma_flag),
        .phase0_en  (phase0_en),
        .phase1_en  (phase1_en)
    );

endmodule

// File: rtl/rx_deser_align_chk.sv
module rx_deser_align_chk
    import rxd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              sig_ok,
    input logic [WORD_W-1:0] word_out,
    input logic              comma_flag,
    input logic              phase0_en,
    input logic              phase1_en
);

    logic armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
        end else begin
            armed <= 1'b1;
        end
    end

    AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(phase0_en && phase1_en)); // R5

    AST_COMMA_ON_P1: assert property (@(posedge clk) disable iff (rst)
        comma_flag |-> phase1_en); // R6

    AST_COMMA_BITS: assert property (@(posedge clk) disable iff (rst)
        comma_flag |-> (word_out[COMMA_W-1:0] == COMMA_PAT)); // R3

    AST_SQUELCH_ONES: assert property (@(posedge clk) disable iff (rst)
        !sig_ok |-> (word_out == '1)); // R7

    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (armed && !phase0_en && !phase1_en && sig_ok && $past(sig_ok))
            |-> $stable(word_out)); // R1

    AST_RST_CLEAN: assert property (@(posedge clk) disable iff (rst)
        !armed |-> (!phase0_en && !phase1_en && !comma_flag)); // R9

endmodule

bind rx_deser_align rx_deser_align_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .sig_ok     (sig_ok),
    .word_out   (word_out),
    .comma_flag (comma_flag),
    .phase0_en  (phase0_en),
    .phase1_en  (phase1_en)
);

// File: tb/rx_deser_align_bench.sv
module rx_deser_align_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_in = 1'b0;
    logic       align_en = 1'b0;
    logic       sig_ok = 1'b1;
    logic [9:0] word_out;
    logic       comma_flag;
    logic       phase0_en;
    logic       phase1_en;

    always #4 clk = ~clk;   // 125 MHz

    rx_deser_align u_rx_deser_align (
        .clk        (clk),
        .rst        (rst),
        .ser_in     (ser_in),
        .align_en   (align_en),
        .sig_ok     (sig_ok),
        .word_out   (word_out),
        .comma_flag (comma_flag),
        .phase0_en  (phase0_en),
        .phase1_en  (phase1_en)
    );

    int    checks = 0;
    int    fails  = 0;
    bit    armed  = 0;
    string tag    = "R9";

    // behavioural reference state
    bit         hist[$];
    int         bit_cnt;
    int         nxt_phase;
    logic [9:0] m_word;
    bit         m_c, m_p0, m_p1;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare();
        logic [9:0] ew;
        ew = sig_ok ? m_word : 10'h3FF;
        chk(sig_ok ? tag : "R7", "word_out", 32'(word_out), 32'(ew));
        chk(sig_ok ? tag : "R8", "comma_flag", 32'(comma_flag),
            32'(m_c & align_en & sig_ok));
        chk(m_c ? "R6" : "R5", "phase1_en", 32'(phase1_en), 32'(m_p1));
        chk("R5", "phase0_en", 32'(phase0_en), 32'(m_p0));
    endtask

    task automatic model_step(input bit b);
        logic [9:0] w;
        bit         match;
        if (rst) begin
            hist.delete();
            for (int i = 0; i < 10; i++) hist.push_back(1'b0);
            bit_cnt = 0; nxt_phase = 0;
            m_word = '0; m_c = 0; m_p0 = 0; m_p1 = 0;
        end else begin
            hist.push_back(b);
            void'(hist.pop_front());
            for (int i = 0; i < 10; i++) w[i] = hist[i];
            match = !hist[0] && !hist[1] && hist[2] && hist[3] &&
                    hist[4] && hist[5] && hist[6];
            m_c = 0; m_p0 = 0; m_p1 = 0;
            if (match && align_en && sig_ok) begin
                m_word = w; m_c = 1; m_p1 = 1;
                bit_cnt = 0; nxt_phase = 0;
            end else if (bit_cnt == 9) begin
                m_word = w;
                if (nxt_phase == 1) m_p1 = 1; else m_p0 = 1;
                nxt_phase = 1 - nxt_phase;
                bit_cnt = 0;
            end else begin
                bit_cnt++;
            end
        end
    endtask

    task automatic step(input bit b, input bit aen, input bit sok, input bit r);
        @(negedge clk);
        if (armed) compare();
        ser_in = b; align_en = aen; sig_ok = sok; rst = r;
        model_step(b);
        armed = 1;
    endtask

    task automatic send_word(input logic [9:0] wd, input bit aen, input bit sok);
        for (int i = 0; i < 10; i++) step(wd[i], aen, sok, 1'b0);
    endtask

    task automatic send_bits(input int n, input logic [31:0] v,
                             input bit aen, input bit sok);
        for (int i = 0; i < n; i++) step(v[i], aen, sok, 1'b0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog act=0 exp=1");
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        // R9: reset state
        tag = "R9";
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b1, 1'b1);
        step(1'b1, 1'b0, 1'b1, 1'b0);
        send_bits(9, 32'h0000_01A3, 1'b0, 1'b1);

        // R1: plain framing, bit 0 first
        tag = "R1";
        send_word(10'h2A5, 1'b0, 1'b1);
        send_word(10'h0F0, 1'b0, 1'b1);
        send_word(10'h155, 1'b0, 1'b1);
        send_word(10'h3C1, 1'b0, 1'b1);

        // R4: misaligned commas ignored when alignment is off
        tag = "R4";
        send_bits(3, 32'h5, 1'b0, 1'b1);
        send_word(10'h17C, 1'b0, 1'b1);
        send_word(10'h27C, 1'b0, 1'b1);
        send_bits(7, 32'h2B, 1'b0, 1'b1);

        // R3: realignment onto a misaligned comma
        tag = "R3";
        send_bits(4, 32'hA, 1'b1, 1'b1);
        send_word(10'h17C, 1'b1, 1'b1);
        send_word(10'h2A5, 1'b1, 1'b1);
        send_word(10'h0C3, 1'b1, 1'b1);
        send_word(10'h199, 1'b1, 1'b1);

        // R2 / R6: comma already on the boundary, repeated
        tag = "R2";
        send_word(10'h37C, 1'b1, 1'b1);
        send_word(10'h2A5, 1'b1, 1'b1);
        send_word(10'h07C, 1'b1, 1'b1);
        send_word(10'h07C, 1'b1, 1'b1);
        send_word(10'h133, 1'b1, 1'b1);

        // R8 / R7: squelched line masks detection and forces ones
        tag = "R8";
        send_bits(5, 32'h15, 1'b1, 1'b0);
        send_word(10'h17C, 1'b1, 1'b0);
        send_word(10'h2A5, 1'b1, 1'b0);
        tag = "R8";
        send_bits(5, 32'h0, 1'b1, 1'b1);
        send_word(10'h155, 1'b1, 1'b1);

        // R3: pseudo-random stream with alignment on
        tag = "R3";
        lfsr = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            step(lfsr[0], 1'b1, (i % 97) < 90, 1'b0);
            lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
        end
        send_word(10'h27C, 1'b1, 1'b1);
        send_word(10'h0AA, 1'b1, 1'b1);
        step(1'b0, 1'b1, 1'b1, 1'b0);
        finish_run();
    end

endmodule